// File: doc/BRIEF.md
# Runtime-Partitioned SIMD Minimum

This combinational unit returns the lane-wise unsigned minimum of two operands. The word is cut into four equal segments. A three-bit partition mask decides at runtime which neighbouring segments merge into one wider lane. The same compare-and-select logic serves every layout: one full-width lane, four narrow lanes, or any mix of the two.

Each lane compares its own slice of `x` and `y` as one unsigned number and passes the smaller slice to `res`. A lane that spans several segments uses a true multi-segment magnitude compare, so its highest differing segment decides. No state is held. The result follows the operands and the mask within the same cycle.

Top module: `simd_min`

## Requirements
- R1: Mask bit k lies between segment k and segment k+1. With the default 4-bit segments, bit 0 separates data bits 3|4, bit 1 separates 7|8, and bit 2 separates 11|12.
- R2: A mask bit of 0 joins the two neighbouring segments into one lane. A mask bit of 1 places a lane boundary there.
- R3: Mask 3'b000 gives one 16-bit lane, and `res` equals the unsigned minimum of `x` and `y`.
- R4: Mask 3'b111 gives four independent 4-bit lanes. Each segment of `res` is the minimum of the matching segments of `x` and `y`.
- R5: All eight mask values are legal, including mixed layouts. Each lane's result depends only on that lane's bits, and every lane of `res` equals either the `x` slice or the `y` slice of that lane.
- R6: Inside a multi-segment lane, a higher segment decides the compare unless the two operands are equal in that segment. When they are equal, the next lower segment decides.
- R7: Comparisons are unsigned. A set top bit counts as a large value.
- R8: When a lane's `x` and `y` slices are equal, that lane of `res` equals both of them.
- R9: The unit is combinational. `res` reflects new operands and a new mask without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | 16 | First operand |
| y | input | 16 | Second operand |
| brk | input | 3 | Partition mask; bit k = 1 places a lane boundary above segment k |
| res | output | 16 | Lane-wise unsigned minimum |

## Verification
The bench runs all eight masks against a reference model that loops over lanes. It uses operands whose lanes disagree in different directions, because a design that ignores a mask bit, or decodes the wrong bit, would then select across a lane boundary. Operands that tie in the upper segment and differ only lower down catch a lane that compares segment by segment and mixes `x` and `y` inside one lane. Patterns with the top bit set catch a signed compare. Equal operands and changes confined to one lane catch leakage of decisions between lanes.

// File: rtl/simd_min.sv
module simd_min #(
  parameter int SEG_W = 4,
  parameter int N_SEG = 4
) (
  input  logic [SEG_W*N_SEG-1:0] x,
  input  logic [SEG_W*N_SEG-1:0] y,
  input  logic [N_SEG-2:0]       brk,
  output logic [SEG_W*N_SEG-1:0] res
);
  localparam int W = SEG_W * N_SEG;

  logic [N_SEG-1:0] seg_lt, seg_eq, chain_lt, pick_x;

  always_comb begin
    for (int i = 0; i < N_SEG; i++) begin
      seg_lt[i] = x[i*SEG_W +: SEG_W] < y[i*SEG_W +: SEG_W];
      seg_eq[i] = x[i*SEG_W +: SEG_W] == y[i*SEG_W +: SEG_W];
    end
    chain_lt[0] = seg_lt[0];
    for (int i = 1; i < N_SEG; i++)
      chain_lt[i] = seg_lt[i] | (seg_eq[i] & ~brk[i-1] & chain_lt[i-1]);
    pick_x[N_SEG-1] = chain_lt[N_SEG-1];
    for (int i = N_SEG - 2; i >= 0; i--)
      pick_x[i] = brk[i] ? chain_lt[i] : pick_x[i+1];
  end

  for (genvar g = 0; g < N_SEG; g++) begin : g_sel
    assign res[g*SEG_W +: SEG_W] = pick_x[g] ? x[g*SEG_W +: SEG_W] : y[g*SEG_W +: SEG_W];
  end

  logic [W-1:0] unused_w;
  assign unused_w = '0;
endmodule

// File: rtl/simd_min_chk.sv
module simd_min_chk #(
  parameter int SEG_W = 4,
  parameter int N_SEG = 4
) (
  input logic [SEG_W*N_SEG-1:0] x,
  input logic [SEG_W*N_SEG-1:0] y,
  input logic [N_SEG-2:0]       brk,
  input logic [SEG_W*N_SEG-1:0] res
);
  always_comb begin
    if (brk == '0) begin
      AST_FULL_MIN: assert (res == ((x < y) ? x : y)) else $error("full width"); // R3
    end
    if (x == y) begin
      AST_EQUAL_PASS: assert (res == x) else $error("equal operands"); // R8
    end
    for (int i = 0; i < N_SEG; i++) begin
      AST_SEG_SOURCE: assert (res[i*SEG_W +: SEG_W] == x[i*SEG_W +: SEG_W] ||
                              res[i*SEG_W +: SEG_W] == y[i*SEG_W +: SEG_W]) else $error("source"); // R5
      if (brk == '1) begin
        AST_SPLIT_MIN: assert (res[i*SEG_W +: SEG_W] ==
          ((x[i*SEG_W +: SEG_W] < y[i*SEG_W +: SEG_W]) ? x[i*SEG_W +: SEG_W] : y[i*SEG_W +: SEG_W]))
          else $error("split"); // R4
      end
    end
  end
endmodule

bind simd_min simd_min_chk #(.SEG_W(SEG_W), .N_SEG(N_SEG)) u_chk (
  .x(x), .y(y), .brk(brk), .res(res)
);

// File: tb/tb_simd_min.sv
module tb_simd_min;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] x, y, res;
  logic [2:0] brk;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  simd_min dut (.x(x), .y(y), .brk(brk), .res(res));

  function automatic logic [15:0] ref_min(logic [15:0] a, logic [15:0] b, logic [2:0] m);
    logic [15:0] r = '0;
    int st = 0;
    for (int s = 0; s < 4; s++) begin
      if (s == 3 || m[s]) begin
        int lo = 4 * st;
        int nb = 4 * (s - st + 1);
        int ma = int'(a >> lo) & ((1 << nb) - 1);
        int mb = int'(b >> lo) & ((1 << nb) - 1);
        int mn = (ma < mb) ? ma : mb;
        r = r | 16'(mn << lo);
        st = s + 1;
      end
    end
    return r;
  endfunction

  task automatic apply_check(input logic [15:0] a, input logic [15:0] b, input logic [2:0] m, input string req);
    logic [15:0] exp;
    x = a; y = b; brk = m;
    #1;
    exp = ref_min(a, b, m);
    checks++;
    if (res !== exp) begin
      errors++;
      $display("FAIL %s x=%h y=%h brk=%b actual=%h expected=%h", req, a, b, m, res, exp);
    end
  endtask

  task automatic t_reset;
    apply_check(16'h0000, 16'h0000, 3'b000, "R8 idle");
  endtask

  task automatic t_boundaries;
    apply_check(16'h0F00, 16'h00FF, 3'b001, "R1");
    apply_check(16'h0F00, 16'h00FF, 3'b010, "R1");
    apply_check(16'h0F00, 16'h00FF, 3'b100, "R1");
    apply_check(16'h1234, 16'h2143, 3'b000, "R2 join");
    apply_check(16'h1234, 16'h2143, 3'b101, "R2 break");
  endtask

  task automatic t_full;
    apply_check(16'hABCD, 16'hABCC, 3'b000, "R3");
    apply_check(16'h0001, 16'hFFFF, 3'b000, "R3");
  endtask

  task automatic t_split;
    apply_check(16'h1F2E, 16'hF1E2, 3'b111, "R4");
    apply_check(16'h0000, 16'hFFFF, 3'b111, "R4");
  endtask

  task automatic t_all_masks;
    for (int m = 0; m < 8; m++)
      for (int k = 0; k < 40; k++)
        apply_check(16'($urandom), 16'($urandom), 3'(m), "R5 random");
  endtask

  task automatic t_isolation;
    apply_check(16'h5300, 16'h3500, 3'b011, "R5 base");
    apply_check(16'h5309, 16'h3570, 3'b011, "R5 lower lanes change");
  endtask

  task automatic t_upper_decides;
    apply_check(16'h7170, 16'h7077, 3'b000, "R6 tie upper");
    apply_check(16'h55A0, 16'h550F, 3'b010, "R6 lower decides");
    apply_check(16'h2F00, 16'h30FF, 3'b100, "R6 upper decides");
  endtask

  task automatic t_unsigned;
    apply_check(16'h8000, 16'h7FFF, 3'b000, "R7");
    apply_check(16'h8888, 16'h7777, 3'b111, "R7");
  endtask

  task automatic t_equal;
    for (int m = 0; m < 8; m++)
      apply_check(16'hC3A5, 16'hC3A5, 3'(m), "R8");
    apply_check(16'hC3A5, 16'hC3A4, 3'b111, "R8 partial");
  endtask

  task automatic t_same_cycle;
    apply_check(16'h4444, 16'h3333, 3'b000, "R9");
    apply_check(16'h4444, 16'h3333, 3'b111, "R9 mask only");
    apply_check(16'h1111, 16'h3333, 3'b111, "R9 operand only");
  endtask

  initial begin
    x = '0; y = '0; brk = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_boundaries();
    t_full();
    t_split();
    t_all_masks();
    t_isolation();
    t_upper_decides();
    t_unsigned();
    t_equal();
    t_same_cycle();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule